// File: doc/BRIEF.md
# Linked-List Receive Descriptor DMA

This engine stores received frame bytes in shared memory by walking a chain of receive descriptors. Software writes the address of the first descriptor into a base address input and pulses `start`. The engine reads the first three words of each descriptor in one three-beat burst:

- a control word,
- a next-descriptor pointer,
- a buffer pointer.

It then takes bytes from a byte stream and packs them into 32-bit words for the buffer.

A descriptor is five words long. When a buffer fills, or a frame ends, the engine writes a completion word into the fourth word of that descriptor. When a frame ends, it also writes the address of the frame's final descriptor into the fifth word of the descriptor where that frame began. Software can then unlink a whole frame without scanning the chain.

A hold bit in the control word parks the engine after that descriptor. A restart strobe makes it read that descriptor again and follow whatever next pointer is found there at that time.

The memory port works as follows:

- It asserts `mem_req` and keeps the address, data, write flag and byte enables stable until a one-cycle `mem_gnt`.
- A read is always a three-word burst. The three words come back on `mem_rvalid` in address order, starting in the cycle after the grant.

Descriptors and buffers are assumed to be 4-byte aligned. Buffer sizes are assumed to be at least 1.

Top module: `rxdesc_dma`

## Requirements
- R1: After reset the engine is idle. A `start` pulse makes it issue a read request at `base_addr`. Every read request is word aligned (address bits 1:0 are zero).
- R2: The burst returns, in order, the control word, the next pointer and the buffer pointer. In the control word, bit 31 is hold, bit 30 is interrupt-enable and bits 15:0 are the buffer size in bytes.
- R3: Bytes are packed little-endian. Byte n of a buffer goes to bits 8*(n mod 4)+7 : 8*(n mod 4) of the word at buffer + 4*(n div 4). A word write enables only the bytes actually received, so other bytes in memory keep their old values.
- R4: When a buffer fills before the frame ends, the completion word has frame-end clear and a count equal to the size. The same frame then continues in the descriptor named by the next pointer.
- R5: The completion word is written to descriptor + 12, after the descriptor's last data write. Its fields are: bit 31 = 1 (complete), bit 30 = frame end, bit 16 = a byte with `rx_err` was seen in this descriptor, and bits 15:0 = bytes stored.
- R6: At frame end, the address of the frame's final descriptor is written to (first descriptor of that frame) + 16. This write comes after the final descriptor's completion word. A frame that fits in one descriptor writes its own address.
- R7: `irq` is a one-cycle pulse after the completion-word write of a descriptor whose interrupt-enable bit is set, and is never asserted otherwise.
- R8: After completing a descriptor with hold set, the engine accepts no bytes and issues no fetch. On `restart` it reads that descriptor again and continues at the next pointer read then.
- R9: `rx_ready` is high only while the engine can take a byte, and never while a memory request is pending.
- R10: A request that has not been granted stays asserted with unchanged address, data and write flag.
- R11: In reset, `mem_req`, `rx_ready` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin walking the chain at base_addr (idle only) |
| restart | input | 1 | Leave the hold state |
| base_addr | input | ADDR_W | First descriptor address |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_err | input | 1 | Frame error flag, given with the byte |
| rx_ready | output | 1 | Engine takes the byte this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = single write, 0 = three-word burst read |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_gnt | input | 1 | One-cycle grant of the pending request |
| mem_rvalid | input | 1 | Read data beat valid |
| mem_rdata | input | 32 | Read data beat |
| irq | output | 1 | Per-descriptor interrupt pulse |

## Verification
The bench goes after these corner cases:

- **Frame exactly fills its buffer.** A design that gets this wrong would either write the completion word twice or clear the frame-end bit.
- **Single-byte frame.** A wrong design would point the fifth word at the wrong descriptor.
- **Buffer that fills in the middle of a frame.** A wrong design would miss the spill into the next descriptor, or start a new frame there.
- **Partial last word.** Bytes are pre-filled with a known pattern, so a wrong byte enable shows up as corruption beyond the count.
- **Hold descriptor whose next pointer is rewritten while parked.** A design that reuses the stale pointer writes status into a decoy descriptor. A design that ignores hold accepts bytes while parked.

// File: rtl/rxdesc_pkg.sv
// Shared types and field positions for the receive descriptor DMA.
// Assumes 32-bit data words and a five-word descriptor.
package rxdesc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_FREQ, ST_FDAT, ST_FILL, ST_DWR, ST_SWR, ST_BWR, ST_HOLD
    } dma_state_t;

    localparam int CW_HOLD_BIT = 31;
    localparam int CW_INT_BIT  = 30;
    localparam int ST_CPL_BIT  = 31;
    localparam int ST_FE_BIT   = 30;
    localparam int ST_ERR_BIT  = 16;
    localparam int OFS_STATUS  = 12;
    localparam int OFS_BACKPTR = 16;
    localparam int FETCH_BEATS = 3;
endpackage

// File: rtl/rxd_desc_regs.sv
// Captures the three-beat descriptor burst into control, next and buffer
// registers. Assumes beats arrive in address order after the grant.
module rxd_desc_regs #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rvalid,
    input  logic [31:0]       rdata,
    output logic [31:0]       ctrl,
    output logic [ADDR_W-1:0] nxt,
    output logic [ADDR_W-1:0] bufp,
    output logic              last_beat
);
    import rxdesc_pkg::*;
    localparam int BW = $clog2(FETCH_BEATS + 1);

    logic [BW-1:0] beat;

    assign last_beat = rvalid && (beat == BW'(FETCH_BEATS - 1));

    // Route each returning beat to its register and advance the beat index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
            ctrl <= '0;
            nxt  <= '0;
            bufp <= '0;
        end else if (clr) begin
            beat <= '0;
        end else if (rvalid) begin
            beat <= beat + 1'b1;
            case (beat)
                BW'(0):  ctrl <= rdata;
                BW'(1):  nxt  <= ADDR_W'(rdata);
                default: bufp <= ADDR_W'(rdata);
            endcase
        end
    end

    // R2: no more than three beats are taken per burst
    assert_beat_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> beat < BW'(FETCH_BEATS));
endmodule

// File: rtl/rxd_pack.sv
// Packs bytes little-endian into one data word with per-lane enables.
// Assumes the caller clears it after each word write.
module rxd_pack #(
    parameter int LANES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     load,
    input  logic [$clog2(LANES)-1:0] lane,
    input  logic [7:0]               din,
    output logic [LANES*8-1:0]       word,
    output logic [LANES-1:0]         be
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Hold the byte for one lane and mark it valid until cleared.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word[g*8 +: 8] <= '0;
                be[g]          <= 1'b0;
            end else if (clr) begin
                be[g] <= 1'b0;
            end else if (load && (lane == g)) begin
                word[g*8 +: 8] <= din;
                be[g]          <= 1'b1;
            end
        end
    end

    // R3: a lane is never filled twice within one word
    assert_lane_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |-> !be[lane]);
endmodule

// File: rtl/rxd_frame_track.sv
// Remembers the descriptor where the current frame began so that the
// back-pointer can be written there at frame end.
module rxd_frame_track #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] cur,
    input  logic              frame_done,
    output logic              in_frame,
    output logic [ADDR_W-1:0] first_desc
);
    // Latch the descriptor of a frame's first byte; release after back-write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame   <= 1'b0;
            first_desc <= '0;
        end else if (frame_done) begin
            in_frame <= 1'b0;
        end else if (accept && !in_frame) begin
            in_frame   <= 1'b1;
            first_desc <= cur;
        end
    end

    // R6: a back-pointer write only closes a frame that was opened
    assert_back_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> in_frame);
endmodule

// File: rtl/rxdesc_dma.sv
// Receive descriptor DMA: fetches descriptors, fills buffers, writes the
// completion word and the frame back-pointer. Assumes aligned descriptors
// and buffers, buffer sizes of at least 1, and SIZE_W <= 16.
module rxdesc_dma #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              restart,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              rx_err,
    output logic              rx_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              irq
);
    import rxdesc_pkg::*;

    dma_state_t        state;
    logic [ADDR_W-1:0] cur, waddr, nxt, bufp, first_desc;
    logic [31:0]       ctrl, pk_word, stat_word;
    logic [3:0]        pk_be;
    logic [SIZE_W-1:0] cnt, cnt_n, size;
    logic              fe, bfull, err_seen, refetch, last_beat, in_frame;
    logic              accept, end_word, frame_done, pk_clr;

    assign size       = ctrl[SIZE_W-1:0];
    assign rx_ready   = (state == ST_FILL);
    assign accept     = rx_ready && rx_valid;
    assign cnt_n      = cnt + 1'b1;
    assign end_word   = (cnt[1:0] == 2'd3) || (cnt_n == size) || rx_last;
    assign frame_done = (state == ST_BWR) && mem_gnt;
    assign pk_clr     = (state == ST_DWR) && mem_gnt;

    rxd_desc_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .clr((state == ST_FREQ) && mem_gnt),
        .rvalid(mem_rvalid && (state == ST_FDAT)), .rdata(mem_rdata),
        .ctrl(ctrl), .nxt(nxt), .bufp(bufp), .last_beat(last_beat)
    );

    rxd_pack #(.LANES(4)) u_pack (
        .clk(clk), .rst_n(rst_n), .clr(pk_clr), .load(accept),
        .lane(cnt[1:0]), .din(rx_data), .word(pk_word), .be(pk_be)
    );

    rxd_frame_track #(.ADDR_W(ADDR_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .accept(accept), .cur(cur),
        .frame_done(frame_done), .in_frame(in_frame), .first_desc(first_desc)
    );

    // Assemble the completion word from the per-descriptor state.
    always_comb begin
        stat_word              = '0;
        stat_word[SIZE_W-1:0]  = cnt;
        stat_word[ST_CPL_BIT]  = 1'b1;
        stat_word[ST_FE_BIT]   = fe;
        stat_word[ST_ERR_BIT]  = err_seen;
    end

    // Drive the memory request for the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur;
        mem_wdata = '0;
        mem_be    = 4'hF;
        case (state)
            ST_FREQ: mem_req = 1'b1;
            ST_DWR: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = waddr; mem_wdata = pk_word; mem_be = pk_be;
            end
            ST_SWR: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = cur + ADDR_W'(OFS_STATUS); mem_wdata = stat_word;
            end
            ST_BWR: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = first_desc + ADDR_W'(OFS_BACKPTR);
                mem_wdata = 32'(cur);
            end
            default: ;
        endcase
    end

    // Main sequencer: fetch, fill, write back, advance or park.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; cur <= '0; waddr <= '0; cnt <= '0;
            fe <= 1'b0; bfull <= 1'b0; err_seen <= 1'b0;
            refetch <= 1'b0; irq <= 1'b0;
        end else begin
            irq <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    cur   <= base_addr;
                    state <= ST_FREQ;
                end
                ST_FREQ: if (mem_gnt) state <= ST_FDAT;
                ST_FDAT: if (last_beat) begin
                    if (refetch) begin
                        cur     <= nxt;
                        refetch <= 1'b0;
                        state   <= ST_FREQ;
                    end else begin
                        cnt <= '0; fe <= 1'b0; bfull <= 1'b0; err_seen <= 1'b0;
                        state <= ST_FILL;
                    end
                end
                ST_FILL: if (accept) begin
                    cnt <= cnt_n;
                    if (rx_err) err_seen <= 1'b1;
                    if (end_word) begin
                        waddr <= bufp + ADDR_W'({cnt[SIZE_W-1:2], 2'b00});
                        fe    <= rx_last;
                        bfull <= (cnt_n == size);
                        state <= ST_DWR;
                    end
                end
                ST_DWR: if (mem_gnt) state <= (fe || bfull) ? ST_SWR : ST_FILL;
                ST_SWR: if (mem_gnt) begin
                    irq <= ctrl[CW_INT_BIT];
                    if (fe)                     state <= ST_BWR;
                    else if (ctrl[CW_HOLD_BIT]) state <= ST_HOLD;
                    else begin cur <= nxt; state <= ST_FREQ; end
                end
                ST_BWR: if (mem_gnt) begin
                    if (ctrl[CW_HOLD_BIT]) state <= ST_HOLD;
                    else begin cur <= nxt; state <= ST_FREQ; end
                end
                ST_HOLD: if (restart) begin
                    refetch <= 1'b1;
                    state   <= ST_FREQ;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: descriptor reads are word aligned
    assert_read_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_addr[1:0] == 2'b00));
    // R10: a pending request keeps its contents until granted
    assert_req_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_wdata) && $stable(mem_we)));
    // R7: the interrupt is a single-cycle pulse
    assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R9: no byte is offered a slot while the bus is in use
    assert_ready_bus_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> !mem_req);
    // R3: every write carries at least one enabled byte
    assert_be_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be != 4'h0));
    // R8: parked engine neither takes bytes nor fetches
    assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> (!rx_ready && !mem_req));
endmodule

// File: tb/rxdesc_dma_tb.sv
// Bench: random frames over a chain of descriptors with directed corner
// cases, compared word by word with a bench-built memory image.
module rxdesc_dma_tb;
    localparam int NDESC = 12;
    localparam int MWORDS = 2048;
    localparam logic [31:0] DECOY = 32'h0E0;
    localparam logic [31:0] TERM  = 32'h0C0;
    localparam int HOLD_IDX = 3;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, restart = 1'b0;
    logic [31:0] base_addr = 32'h100;
    logic rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
    logic [7:0] rx_data = '0;
    logic rx_ready, mem_req, mem_we, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0] mem_be;
    logic mem_gnt, mem_rvalid;

    rxdesc_dma u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .restart(restart),
        .base_addr(base_addr), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_err(rx_err), .rx_ready(rx_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    logic [31:0] mem  [0:MWORDS-1];
    logic [31:0] emem [0:MWORDS-1];
    int          wtime[0:MWORDS-1];
    int wseq = 1, beats = 0, nchk = 0, nbad = 0, irq_cnt = 0, exp_irq = 0;
    logic [31:0] raddr, first_rd = '1;
    bit done = 0;

    // Memory model: random grant delay, writes applied at grant, 3-beat reads.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_gnt <= 1'b0; mem_rvalid <= 1'b0; mem_rdata <= '0; beats <= 0;
        end else begin
            mem_gnt <= 1'b0; mem_rvalid <= 1'b0;
            if (beats > 0) begin
                mem_rvalid <= 1'b1; mem_rdata <= mem[raddr[12:2]];
                raddr <= raddr + 4; beats <= beats - 1;
            end else if (mem_req && !mem_gnt && ($urandom % 3 == 0)) begin
                mem_gnt <= 1'b1;
                if (mem_we) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) mem[mem_addr[12:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
                    wtime[mem_addr[12:2]] <= wseq; wseq <= wseq + 1;
                end else begin
                    if (first_rd == '1) first_rd <= mem_addr;
                    raddr <= mem_addr; beats <= 3;
                end
            end
        end
    end

    always @(negedge clk) if (rst_n && irq) irq_cnt++;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int a);
        if (a >= 32'h1000) return "R3/R4 buffer";
        if (a[4:0] == 5'd12) return "R5 completion";
        if (a[4:0] == 5'd16) return "R6 backptr";
        return "R8 descriptor";
    endfunction

    logic [31:0] daddr[NDESC], dbuf[NDESC];
    int dsize[NDESC];
    bit dint[NDESC], dhold[NDESC];
    int di = 0, fill = 0, ffirst = 0, nfr = 0;
    bit in_fr = 0, serr = 0, pend_hold = 0;
    int fr_first[64], fr_last[64];

    function automatic int room();
        int r = -fill;
        for (int k = di; k < NDESC; k++) r += dsize[k];
        return r;
    endfunction

    task automatic do_hold();
        int ready_seen = 0, guard = 0;
        while (mem[(daddr[HOLD_IDX] + 12) >> 2] == 0 && guard < 2000) begin
            @(negedge clk); guard++;
        end
        repeat (30) begin @(negedge clk); if (rx_ready) ready_seen++; end
        chk(ready_seen == 0, "R8", "bytes taken while held", ready_seen, 0);
        chk(mem[(DECOY + 12) >> 2] == 0, "R8", "decoy touched", mem[(DECOY + 12) >> 2], 0);
        mem[(daddr[HOLD_IDX] + 4) >> 2]  = daddr[HOLD_IDX + 1];
        emem[(daddr[HOLD_IDX] + 4) >> 2] = daddr[HOLD_IDX + 1];
        @(negedge clk) restart = 1'b1;
        @(negedge clk) restart = 1'b0;
        pend_hold = 0;
    endtask

    task automatic model_byte(input logic [7:0] b, input bit last, input bit err);
        logic [31:0] a;
        if (!in_fr) begin ffirst = di; in_fr = 1; end
        a = dbuf[di] + fill;
        emem[a >> 2][a[1:0]*8 +: 8] = b;
        fill++;
        if (err) serr = 1;
        if (last || fill == dsize[di]) begin
            emem[(daddr[di] + 12) >> 2] = 32'h8000_0000 | (32'(last) << 30) |
                                           (32'(serr) << 16) | 32'(fill);
            if (dint[di]) exp_irq++;
            if (last) begin
                emem[(daddr[ffirst] + 16) >> 2] = daddr[di];
                fr_first[nfr] = ffirst; fr_last[nfr] = di; nfr++;
                in_fr = 0;
            end
            if (dhold[di]) pend_hold = 1;
            di++; fill = 0; serr = 0;
        end
    endtask

    task automatic send_frame(input int len, input bit err);
        for (int k = 0; k < len; k++) begin
            logic [7:0] b = 8'($urandom);
            bit last = (k == len - 1);
            if (pend_hold) do_hold();
            @(negedge clk);
            rx_valid = 1'b1; rx_data = b; rx_last = last; rx_err = last && err;
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
            rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
            model_byte(b, last, last && err);
            repeat ($urandom % 3) @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd20534));
        for (int w = 0; w < MWORDS; w++) begin
            mem[w] = (w >= 32'h400) ? 32'hA5A5_A5A5 : 32'h0; wtime[w] = 0;
        end
        for (int i = 0; i < NDESC; i++) begin
            daddr[i] = 32'h100 + 32'(i) * 32'h20;
            dbuf[i]  = 32'h1000 + 32'(i) * 32'h40;
            dsize[i] = (i == 0) ? 5 : (i == 1) ? 8 : 1 + int'($urandom % 24);
            dint[i]  = 1'($urandom);
            dhold[i] = (i == HOLD_IDX);
        end
        for (int i = 0; i < NDESC; i++) begin
            mem[daddr[i] >> 2] = (32'(dhold[i]) << 31) | (32'(dint[i]) << 30) | 32'(dsize[i]);
            mem[(daddr[i] >> 2) + 1] = (i == NDESC - 1) ? TERM :
                                       dhold[i] ? DECOY : daddr[i + 1];
            mem[(daddr[i] >> 2) + 2] = dbuf[i];
        end
        mem[TERM >> 2] = 32'd1000; mem[(TERM >> 2) + 1] = TERM; mem[(TERM >> 2) + 2] = 32'h1800;
        mem[DECOY >> 2] = 32'd16; mem[(DECOY >> 2) + 1] = TERM; mem[(DECOY >> 2) + 2] = 32'h1C00;
        for (int w = 0; w < MWORDS; w++) emem[w] = mem[w];

        repeat (3) @(negedge clk);
        chk(!mem_req && !rx_ready && !irq, "R11", "outputs in reset",
            {29'd0, mem_req, rx_ready, irq}, 0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(!mem_req, "R1", "request before start", 32'(mem_req), 0);
        start = 1'b1; @(negedge clk) start = 1'b0;

        send_frame(5, 0);   // exactly fills desc0
        send_frame(1, 1);   // single byte with error
        for (int f = 0; f < 40; f++) begin
            int len = 1 + int'($urandom % 40);
            if (len > room()) break;
            send_frame(len, bit'($urandom % 4 == 0));
        end
        repeat (300) @(negedge clk);

        chk(first_rd == base_addr, "R1", "first fetch address", first_rd, base_addr);
        chk(di > HOLD_IDX + 1, "R8", "chain passed held descriptor", di, HOLD_IDX + 2);
        for (int w = 0; w < MWORDS; w++)
            chk(mem[w] === emem[w], tag_of(w * 4), $sformatf("word @%0h", w * 4), mem[w], emem[w]);
        for (int f = 0; f < nfr; f++)
            chk(wtime[(daddr[fr_first[f]] + 16) >> 2] > wtime[(daddr[fr_last[f]] + 12) >> 2],
                "R6", "backptr before completion", wtime[(daddr[fr_first[f]] + 16) >> 2],
                wtime[(daddr[fr_last[f]] + 12) >> 2]);
        chk(irq_cnt == exp_irq, "R7", "interrupt pulses", irq_cnt, exp_irq);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
            $finish;
        end
    end
endmodule